// File: doc/BRIEF.md
# Narrow-Write Wide-Read Gather RAM

This block is a synchronous simple dual-port memory. The write side stores one narrow word per narrow address. The read side is wider by a power-of-two factor set by `RATIO_LOG2`. Each read returns one wide word made of `2^RATIO_LOG2` narrow words that sit next to each other in the narrow address space. The narrow word with the lowest address goes into the most significant lane.

A typical use is a producer that emits a byte or half-word stream while a consumer wants whole words. The two ports have their own clocks, and they may be tied to the same clock. Internally the storage is split into one bank per lane. The low bits of the write address choose the bank, so every wide read reads all banks in parallel at the same row.

One reset input, asynchronous and active low, is taken into each clock domain. It is asserted at once and released in step with that domain's clock. While the write domain is held in reset, writes are blocked. While the read domain is held in reset, the read output is cleared.

Top module: `gather_ram`

## Requirements
- R1: While `rst_n` is low, `rd_data` is all zeros.
- R2: `rd_data` is `DATA_W << RATIO_LOG2` bits wide; with the defaults (8-bit narrow data, `RATIO_LOG2`=2) it is 32 bits.
- R3: Wide read address R returns the narrow words stored at narrow addresses `(R << RATIO_LOG2)` through `(R << RATIO_LOG2) + 2^RATIO_LOG2 - 1`.
- R4: Inside a wide word, lane order is fixed by narrow address. The lowest narrow address occupies bits `[RD_W-1 -: DATA_W]`, and each higher address takes the next lower lane. For example, 0xde, 0xad, 0xbe, 0xef written in ascending address order read back as 0xdeadbeef.
- R5: `rd_addr` is sampled on a rising `clk_rd` edge, and the matching wide word appears on `rd_data` after that same edge. A new address can be issued every cycle.
- R6: When `wr_en` is low on a `clk_wr` edge, no location changes, whatever `wr_addr` and `wr_data` hold.
- R7: A write changes only the one lane selected by the low `RATIO_LOG2` bits of `wr_addr`. The other lanes of the same wide word keep their contents.
- R8: With both clocks tied, a read and a write to the same wide word on the same edge return the contents from before that write. The new value is visible from the next read onward.
- R9: A write presented while the write-domain reset is in effect (`rst_n` low, and for the two `clk_wr` edges after it rises) stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr | input | 1 | Write-side clock |
| clk_rd | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain in step with its clock |
| wr_en | input | 1 | Write enable for the narrow port |
| wr_addr | input | ADDR_W | Narrow word address |
| wr_data | input | DATA_W | Narrow word to store |
| rd_addr | input | ADDR_W-RATIO_LOG2 | Wide word address |
| rd_data | output | DATA_W<<RATIO_LOG2 | Registered wide read word, lowest narrow address in the top lane |

## Verification
The hardest situation to reach from the ports is a write and a read landing on the same wide word at the same clock edge. The bench ties both clocks together and drives the write and the read address in the same half-cycle. It then checks that the old word comes back first and the new word one read later. A second awkward case is a write attempted while reset is held. The bench asserts reset again in the middle of the run, keeps a write to a known location active through the reset, and afterwards reads that location back unchanged. Partial overwrites of single lanes and back-to-back reads at the lowest and highest wide addresses cover lane order and the one-cycle read latency.

// File: rtl/gram_pkg.sv
package gram_pkg;

  // Bit offset of a lane inside the wide read word. Lane 0 holds the
  // lowest narrow address and is placed in the most significant slot.
  function automatic int unsigned lane_lsb(input int unsigned lane,
                                           input int unsigned lanes,
                                           input int unsigned width);
    return (lanes - 1 - lane) * width;
  endfunction

endpackage

// File: rtl/gram_rst_sync.sv
module gram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Shift ones in after release; assertion is asynchronous.
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/gram_wr_decode.sv
module gram_wr_decode #(
  parameter int ADDR_W     = 10,
  parameter int RATIO_LOG2 = 2,
  localparam int LANES     = 1 << RATIO_LOG2,
  localparam int ROW_W     = ADDR_W - RATIO_LOG2
) (
  input  logic              wr_en,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  lane_we,
  output logic [ROW_W-1:0]  wr_row
);

  logic wr_go;

  always_comb begin
    wr_go  = wr_en & wr_ok;
    wr_row = wr_addr[ADDR_W-1:RATIO_LOG2];
  end

  generate
    if (RATIO_LOG2 == 0) begin : g_single
      always_comb begin
        lane_we = wr_go;
      end
    end else begin : g_multi
      for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
          lane_we[i] = wr_go && (wr_addr[RATIO_LOG2-1:0] == RATIO_LOG2'(i));
        end
      end
    end
  endgenerate

endmodule

// File: rtl/gram_lane_bank.sv
module gram_lane_bank #(
  parameter int ROW_W  = 8,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic              clk_wr,
  input  logic              rst_wr_n,
  input  logic              we,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clk_rd,
  input  logic              rst_rd_n,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_next;

  // Storage: no reset, written only under the lane enable.
  always_ff @(posedge clk_wr) begin
    if (we) begin
      mem[wr_row] <= wr_data;
    end
  end

  always_comb begin
    rd_next = mem[rd_row];
  end

  // Registered read lane, cleared by the read-domain reset.
  always_ff @(posedge clk_rd or negedge rst_rd_n) begin
    if (!rst_rd_n) begin
      rd_word <= '0;
    end else begin
      rd_word <= rd_next;
    end
  end

  // R7: an enabled write lands at its row in this lane.
  assert_write_lands_R7: assert property (@(posedge clk_wr) disable iff (!rst_wr_n)
    we |=> mem[$past(wr_row)] === $past(wr_data));

  // R6: without the enable, the addressed row keeps its value.
  assert_no_write_R6: assert property (@(posedge clk_wr) disable iff (!rst_wr_n)
    !we |=> mem[$past(wr_row)] === $past(mem[wr_row]));

  // R5: the lane output after an edge is the row sampled at that edge.
  assert_read_latency_R5: assert property (@(posedge clk_rd) disable iff (!rst_rd_n)
    1'b1 |=> rd_word === $past(mem[rd_row]));

endmodule

// File: rtl/gather_ram.sv
module gather_ram #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int RATIO_LOG2 = 2,
  parameter int SYNC_STAGES = 2,
  localparam int LANES     = 1 << RATIO_LOG2,
  localparam int ROW_W     = ADDR_W - RATIO_LOG2,
  localparam int RD_W      = DATA_W << RATIO_LOG2
) (
  input  logic              clk_wr,
  input  logic              clk_rd,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ROW_W-1:0]  rd_addr,
  output logic [RD_W-1:0]   rd_data
);

  logic              wr_rst_n;
  logic              rd_rst_n;
  logic [LANES-1:0]  lane_we;
  logic [ROW_W-1:0]  wr_row;
  logic [DATA_W-1:0] lane_word [LANES];

  gram_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk    (clk_wr),
    .arst_n (rst_n),
    .srst_n (wr_rst_n)
  );

  gram_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk    (clk_rd),
    .arst_n (rst_n),
    .srst_n (rd_rst_n)
  );

  gram_wr_decode #(
    .ADDR_W     (ADDR_W),
    .RATIO_LOG2 (RATIO_LOG2)
  ) u_decode (
    .wr_en   (wr_en),
    .wr_ok   (wr_rst_n),
    .wr_addr (wr_addr),
    .lane_we (lane_we),
    .wr_row  (wr_row)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_bank
      gram_lane_bank #(
        .ROW_W  (ROW_W),
        .DATA_W (DATA_W)
      ) u_bank (
        .clk_wr   (clk_wr),
        .rst_wr_n (wr_rst_n),
        .we       (lane_we[i]),
        .wr_row   (wr_row),
        .wr_data  (wr_data),
        .clk_rd   (clk_rd),
        .rst_rd_n (rd_rst_n),
        .rd_row   (rd_addr),
        .rd_word  (lane_word[i])
      );

      // R4: lane 0 (lowest narrow address) lands in the top slot.
      assign rd_data[gram_pkg::lane_lsb(i, LANES, DATA_W) +: DATA_W] = lane_word[i];
    end
  endgenerate

  // R7: one enabled write selects exactly one lane.
  assert_one_lane_R7: assert property (@(posedge clk_wr) disable iff (!wr_rst_n)
    wr_en |-> $countones(lane_we) == 1);

  // R6: no lane is enabled while the write enable is low.
  assert_idle_lanes_R6: assert property (@(posedge clk_wr) disable iff (!wr_rst_n)
    !wr_en |-> lane_we == '0);

  // R9: the write-domain reset blocks every lane enable.
  always_comb begin
    if (!wr_rst_n) begin
      assert_reset_blocks_R9: assert (lane_we == '0);
    end
  end

endmodule

// File: tb/gather_ram_bench.sv
`timescale 1ns/1ps
module gather_ram_bench;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int SHIFT  = 2;
  localparam int LANES  = 1 << SHIFT;
  localparam int ROW_W  = ADDR_W - SHIFT;
  localparam int RD_W   = DATA_W << SHIFT;

  typedef struct {
    logic [RD_W-1:0] exp;
    string           req;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [ROW_W-1:0]  rd_addr = '0;
  logic [RD_W-1:0]   rd_data;

  logic [DATA_W-1:0] model [1 << ADDR_W];
  item_t pend_q[$];
  item_t cmp_q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  always #2.5 clk = ~clk;

  gather_ram #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .RATIO_LOG2 (SHIFT)
  ) u_gather_ram (
    .clk_wr  (clk),
    .clk_rd  (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  task automatic check(input logic [RD_W-1:0] act, input logic [RD_W-1:0] exp,
                       input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [RD_W-1:0] wide_of(input int row);
    logic [RD_W-1:0] w = '0;
    for (int l = 0; l < LANES; l++) begin
      w = {w[RD_W-DATA_W-1:0], model[row * LANES + l]};
    end
    return w;
  endfunction

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    model[a] = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input int row, input string req);
    item_t it;
    @(negedge clk);
    rd_addr = ROW_W'(row);
    it.exp = wide_of(row);
    it.req = req;
    pend_q.push_back(it);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  // Monitor: the address is sampled at the posedge after it was driven,
  // and the result is compared at the following negedge.
  always @(posedge clk) begin
    if (pend_q.size() > 0) cmp_q.push_back(pend_q.pop_front());
  end

  always @(negedge clk) begin
    if (cmp_q.size() > 0) begin
      item_t it;
      it = cmp_q.pop_front();
      check(rd_data, it.exp, it.req);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(rd_data, '0, "R1 reset clears output");
    check(RD_W'($bits(rd_data)), RD_W'(32), "R2 read width");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3/R4: ascending-order lanes at wide row 0x21
    wr(32'h84, 8'hde); wr(32'h85, 8'had); wr(32'h86, 8'hbe); wr(32'h87, 8'hef);
    rd(32'h21, "R4 lowest address in top lane");
    drain();
    check(rd_data, 32'hdeadbeef, "R4 deadbeef literal");

    // R3 boundaries: lowest and highest wide rows
    wr(0, 8'h01); wr(1, 8'h02); wr(2, 8'h03); wr(3, 8'h04);
    wr(1020, 8'ha1); wr(1021, 8'ha2); wr(1022, 8'ha3); wr(1023, 8'ha4);
    // Lanes written in descending address order
    wr(23, 8'h44); wr(22, 8'h33); wr(21, 8'h22); wr(20, 8'h11);
    rd(0, "R3 wide row 0");
    rd(255, "R3 wide row 255");
    rd(5, "R4 descending write order");

    // R5: back-to-back reads, a new address every cycle
    rd(32'h21, "R5 back-to-back a");
    rd(0, "R5 back-to-back b");
    rd(32'h21, "R5 back-to-back c");
    rd(255, "R5 back-to-back d");
    drain();

    // R6: disabled write with live address and data
    @(negedge clk);
    wr_en = 1'b0; wr_addr = ADDR_W'(32'h85); wr_data = 8'hff;
    @(negedge clk);
    rd(32'h21, "R6 disabled write ignored");
    drain();

    // R7: single-lane overwrite keeps the neighbours
    wr(32'h86, 8'h77);
    rd(32'h21, "R7 single lane overwrite");
    drain();
    check(rd_data, 32'hdead77ef, "R7 neighbour lanes kept");

    // R8: same-edge write and read of one wide word
    begin
      item_t it;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(32'h84); wr_data = 8'h12;
      rd_addr = ROW_W'(32'h21);
      it.exp = wide_of(32'h21);
      it.req = "R8 collision returns old word";
      pend_q.push_back(it);
      model[32'h84] = 8'h12;
      @(posedge clk);
      #1 wr_en = 1'b0;
    end
    rd(32'h21, "R8 new word on next read");
    drain();
    check(rd_data, 32'h12ad77ef, "R8 new word literal");

    // R9/R1: reset again with a write held active
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b1; wr_addr = ADDR_W'(32'h87); wr_data = 8'h55;
    @(negedge clk);
    check(rd_data, '0, "R1 output cleared in reset");
    repeat (2) @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(32'h21, "R9 write during reset ignored");

    // Sweep rows 8..15 with a computed pattern, then read back in a burst
    for (int r = 8; r < 16; r++) begin
      for (int l = 0; l < LANES; l++) begin
        wr(r * LANES + l, DATA_W'(r * 16 + l * 3 + 1));
      end
    end
    for (int r = 8; r < 16; r++) begin
      rd(r, "R3 sweep");
    end
    drain();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule